// File: doc/BRIEF.md
# Far-End Fault Unit

This block raises and recognises the far-end fault idle pattern on a 100 Mb/s code-group bit stream, one bit per clock. The pattern is a run of 84 ones followed by a single zero. On the send side the block normally passes the encoded transmit stream through. Suppose the link monitor has reported a good link, signal detect is then lost, and the function is enabled. The block then stops forwarding the transmit stream and sends the fault pattern instead, until signal detect returns. The zero of the pattern is always placed on the last bit of a 5-bit code group. The pattern therefore reads as sixteen idle groups and one data-zero group.

On the receive side the block watches the incoming stream for the same pattern. It counts patterns that arrive back to back. On the third and on every later one, it sets a sticky far-end fault flag, which stays set until a status read clears it. While the flag is set, both MII enables are withdrawn. The transmit enable is also withdrawn while the block is itself sending the fault pattern. A carrier indication is produced only for closely spaced zeros, so the fault pattern never counts as carrier.

Top module: `far_fault_unit`

## Requirements
- R1: Out of reset the send stream output is 1, alarm_tx, far_fault and rx_carrier are 0, and both MII allow outputs are 1.
- R2: When no fault pattern is being sent, txs_out equals the value txs_in had one clock earlier.
- R3: alarm_tx rises one clock after sig_present is sampled low, but only if three conditions all hold: cfg_enable is 1, link_good and sig_present were both 1 at an earlier clock, and sig_present has stayed 1 since then. Without such a qualifying good link, or with cfg_enable at 0, losing signal never starts the alarm.
- R4: While alarm_tx is 1, txs_out ignores txs_in and sends ones. A zero is sent only on clocks whose count since reset release is a multiple of 5, which marks the end of a code group. The first zero comes at the earliest such clock at least 85 clocks after alarm_tx rose. Each later zero follows the one before by exactly 85 clocks.
- R5: alarm_tx falls one clock after sig_present is sampled high, or one clock after cfg_enable is sampled low.
- R6: A received pattern is accepted when a run of at least 84 ones, then one zero, then a one arrives on rxs_in. The accepting one counts as the first one of the next run. The third consecutive accepted pattern, and every one after it, makes far_fault 1 two clocks after the accepting one is sampled.
- R7: Any zero that ends a run shorter than 84 ones clears the consecutive-pattern count. So does a zero that follows an accepted zero.
- R8: far_fault stays 1 until stat_read is sampled high, and then it reads 0 on the next clock. If a new setting event arrives in the same clock as the read, the flag stays 1.
- R9: While far_fault is 1, mii_tx_ok and mii_rx_ok are 0. While alarm_tx is 1, mii_tx_ok is 0.
- R10: rx_carrier pulses for one clock after a zero is sampled that came fewer than 10 ones after the previous zero. Zeros spaced 10 or more ones apart, which includes every zero of the fault pattern, never raise it.
- R11: While cfg_enable is 0 received patterns are not counted and far_fault is not set. Counting starts from zero once cfg_enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Enables fault generation and detection |
| link_good | input | 1 | Link monitor reports a good link |
| sig_present | input | 1 | Optical signal detect |
| txs_in | input | 1 | Encoded transmit bit from the upstream encoder |
| txs_out | output | 1 | Transmit bit toward the line |
| alarm_tx | output | 1 | Fault pattern is being sent |
| rxs_in | input | 1 | Received code-group bit |
| stat_read | input | 1 | Management read of the fault status |
| far_fault | output | 1 | Sticky far-end fault flag |
| rx_carrier | output | 1 | Carrier indication pulse |
| mii_tx_ok | output | 1 | MII transmit allowed |
| mii_rx_ok | output | 1 | MII receive allowed |

## Verification
Two functions can fall in the same clock: clearing the sticky flag on a status read, and setting it on a third accepted pattern. The bench sends three patterns and then the accepting one. It asserts stat_read in exactly the clock in which the registered acceptance reaches the flag logic. The flag must still read 1 after that clock and must clear only on a later read with no new pattern. The sweeps also run a fault session at every code-group phase, with the transmit input toggling, and scan received run lengths around the 84-one threshold.

// File: rtl/far_fault_pkg.sv
package far_fault_pkg;

    typedef enum logic {
        TX_PASS  = 1'b0,
        TX_FAULT = 1'b1
    } tx_mode_e;

endpackage

// File: rtl/far_fault_tx.sv
module far_fault_tx
    import far_fault_pkg::*;
#(
    parameter int ONES_LEN = 84,
    parameter int GROUP_W  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic link_ok,
    input  logic sig_ok,
    input  logic bit_in,
    output logic bit_out,
    output logic sending
);
    localparam int RUN_W = $clog2(ONES_LEN + 1);
    localparam int GP_W  = $clog2(GROUP_W);

    typedef struct packed {
        tx_mode_e          mode;
        logic              armed;
        logic [GP_W-1:0]   gpos;
        logic [RUN_W-1:0]  ones;
        logic              bit_o;
    } tx_st_t;

    tx_st_t q, d;
    logic   pat_bit;

    always_comb begin
        d = q;
        // free-running code-group position
        d.gpos = (q.gpos == GP_W'(GROUP_W - 1)) ? '0 : q.gpos + GP_W'(1);
        // zero only on the last bit of a group, once the run is long enough
        pat_bit = !((q.gpos == GP_W'(GROUP_W - 1)) && (q.ones >= RUN_W'(ONES_LEN)));
        if (q.mode == TX_FAULT) begin
            d.bit_o = pat_bit;
            if (!pat_bit)
                d.ones = '0;
            else if (q.ones < RUN_W'(ONES_LEN))
                d.ones = q.ones + RUN_W'(1);
        end else begin
            d.bit_o = bit_in;
            d.ones  = '0;
        end
        // arming: good link seen while signal present, lost with the signal
        d.armed = sig_ok ? (q.armed | link_ok) : 1'b0;
        if (!enable)
            d.mode = TX_PASS;
        else if (q.mode == TX_FAULT)
            d.mode = sig_ok ? TX_PASS : TX_FAULT;
        else
            d.mode = (q.armed && !sig_ok) ? TX_FAULT : TX_PASS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode  <= TX_PASS;
            q.armed <= 1'b0;
            q.gpos  <= '0;
            q.ones  <= '0;
            q.bit_o <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign bit_out = q.bit_o;
    assign sending = (q.mode == TX_FAULT);

    // R3: the alarm only starts on a lost signal with the function enabled
    p_entry_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sending) |-> ($past(enable) && !$past(sig_ok)));

    // R5: with signal still absent and enabled, the alarm holds
    p_alarm_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && enable && !sig_ok) |=> sending);

    // R5: clearing the enable ends the alarm
    p_disable_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sending);

    // R4: a pattern zero is always followed by a one
    p_zero_then_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && $past(sending) && !bit_out) |=> bit_out);

endmodule

// File: rtl/far_fault_rx.sv
module far_fault_rx #(
    parameter int ONES_LEN   = 84,
    parameter int DETECT_MIN = 3,
    parameter int CARR_WIN   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_in,
    output logic hit,
    output logic carrier
);
    localparam int RUN_W = $clog2(ONES_LEN + 1);
    localparam int CNT_W = $clog2(DETECT_MIN + 1);
    localparam int GAP_W = $clog2(CARR_WIN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             pend;
        logic [CNT_W-1:0] cnt;
        logic [GAP_W-1:0] gap;
        logic             hit;
        logic             carr;
    } rx_st_t;

    rx_st_t           q, d;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        d       = q;
        d.hit   = 1'b0;
        cnt_inc = (q.cnt < CNT_W'(DETECT_MIN)) ? q.cnt + CNT_W'(1) : q.cnt;

        // carrier: two zeros close together
        d.carr = !bit_in && (q.gap < GAP_W'(CARR_WIN));
        if (!bit_in)
            d.gap = '0;
        else if (q.gap < GAP_W'(CARR_WIN))
            d.gap = q.gap + GAP_W'(1);

        // pattern recogniser
        if (q.pend) begin
            d.pend = 1'b0;
            if (bit_in) begin
                d.run = RUN_W'(1);
                d.cnt = cnt_inc;
                d.hit = (cnt_inc == CNT_W'(DETECT_MIN));
            end else begin
                d.run = '0;
                d.cnt = '0;
            end
        end else if (bit_in) begin
            if (q.run < RUN_W'(ONES_LEN))
                d.run = q.run + RUN_W'(1);
        end else begin
            if (q.run >= RUN_W'(ONES_LEN))
                d.pend = 1'b1;
            else
                d.cnt = '0;
            d.run = '0;
        end

        if (!enable) begin
            d.pend = 1'b0;
            d.cnt  = '0;
            d.hit  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run  <= '0;
            q.pend <= 1'b0;
            q.cnt  <= '0;
            q.gap  <= GAP_W'(CARR_WIN);
            q.hit  <= 1'b0;
            q.carr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hit     = q.hit;
    assign carrier = q.carr;

    // R11: no detection while disabled
    p_hit_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(enable));

    // R6: acceptance happens on the one after the pattern zero
    p_hit_on_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(bit_in));

    // R10: carrier only follows a received zero
    p_carrier_on_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        carrier |-> !$past(bit_in));

endmodule

// File: rtl/far_fault_status.sv
module far_fault_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd,
    input  logic sending,
    output logic flag,
    output logic tx_ok,
    output logic rx_ok
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        // a new event outranks a read in the same clock
        d.flag = hit | (q.flag & !rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q.flag <= 1'b0;
        else
            q <= d;
    end

    assign flag  = q.flag;
    assign tx_ok = !(q.flag | sending);
    assign rx_ok = !q.flag;

    // R8: an event sets the flag even when a read coincides
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R8: the flag only falls after a read
    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(rd));

endmodule

// File: rtl/far_fault_unit.sv
module far_fault_unit #(
    parameter int ONES_LEN   = 84,
    parameter int GROUP_W    = 5,
    parameter int DETECT_MIN = 3,
    parameter int CARR_WIN   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_enable,
    input  logic link_good,
    input  logic sig_present,
    input  logic txs_in,
    output logic txs_out,
    output logic alarm_tx,
    input  logic rxs_in,
    input  logic stat_read,
    output logic far_fault,
    output logic rx_carrier,
    output logic mii_tx_ok,
    output logic mii_rx_ok
);
    logic rx_hit;

    far_fault_tx #(
        .ONES_LEN (ONES_LEN),
        .GROUP_W  (GROUP_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .link_ok (link_good),
        .sig_ok  (sig_present),
        .bit_in  (txs_in),
        .bit_out (txs_out),
        .sending (alarm_tx)
    );

    far_fault_rx #(
        .ONES_LEN   (ONES_LEN),
        .DETECT_MIN (DETECT_MIN),
        .CARR_WIN   (CARR_WIN)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .bit_in  (rxs_in),
        .hit     (rx_hit),
        .carrier (rx_carrier)
    );

    far_fault_status u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (rx_hit),
        .rd      (stat_read),
        .sending (alarm_tx),
        .flag    (far_fault),
        .tx_ok   (mii_tx_ok),
        .rx_ok   (mii_rx_ok)
    );

    // R9: a raised flag blocks both MII directions
    p_flag_blocks_mii_r9: assert property (@(posedge clk) disable iff (!rst_n)
        far_fault |-> (!mii_tx_ok && !mii_rx_ok));

endmodule

// File: tb/sim_far_fault_unit.sv
module sim_far_fault_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b1;
    logic link_good = 1'b0;
    logic sig_present = 1'b0;
    logic txs_in = 1'b1;
    logic rxs_in = 1'b1;
    logic stat_read = 1'b0;
    logic txs_out, alarm_tx, far_fault, rx_carrier, mii_tx_ok, mii_rx_ok;

    int n_chk = 0;
    int n_fail = 0;
    int ecnt = 0;
    int carr_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    far_fault_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .link_good(link_good),
        .sig_present(sig_present), .txs_in(txs_in), .txs_out(txs_out),
        .alarm_tx(alarm_tx), .rxs_in(rxs_in), .stat_read(stat_read),
        .far_fault(far_fault), .rx_carrier(rx_carrier),
        .mii_tx_ok(mii_tx_ok), .mii_rx_ok(mii_rx_ok)
    );

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;
    always @(posedge clk) if (rst_n && rx_carrier) carr_cnt <= carr_cnt + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rx_send(input logic b);
        rxs_in = b;
        step();
    endtask

    task automatic rx_pat(input int len);
        for (int i = 0; i < len; i++) rx_send(1'b1);
        rx_send(1'b0);
    endtask

    task automatic rx_pre();
        for (int i = 0; i < 20; i++) rx_send(1'b1);
        rx_send(1'b0);
    endtask

    task automatic do_read();
        rxs_in = 1'b1;
        stat_read = 1'b1;
        step();
        stat_read = 1'b0;
    endtask

    task automatic arm();
        cfg_enable = 1'b1;
        sig_present = 1'b1;
        link_good = 1'b1;
        repeat (3) step();
    endtask

    task automatic tx_session(input int ph);
        int f, e0, last, nz, expz;
        arm();
        while ((ecnt % 5) != ph) step();
        sig_present = 1'b0;
        step();
        f = ecnt;
        check("R3 alarm rises", alarm_tx, 1);
        check("R9 tx gated by alarm", mii_tx_ok, 0);
        check("R9 rx open during alarm", mii_rx_ok, 1);
        e0 = f + 85;
        while ((e0 % 5) != 0) e0++;
        last = -1;
        nz = 0;
        for (int k = 0; k < 300; k++) begin
            txs_in = k[0];
            step();
            if (txs_out == 1'b0) begin
                check("R4 zero on group end", ecnt % 5, 0);
                if (last < 0) check("R4 first zero clock", ecnt, e0);
                else check("R4 zero spacing", ecnt - last, 85);
                last = ecnt;
                nz++;
            end
        end
        expz = (e0 <= f + 300) ? 1 + (f + 300 - e0) / 85 : 0;
        check("R4 zero count", nz, expz);
        txs_in = 1'b1;
        sig_present = 1'b1;
        step();
        check("R5 alarm ends on signal", alarm_tx, 0);
        check("R9 tx open after alarm", mii_tx_ok, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        bit expb;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 txs_out", txs_out, 1);
        check("R1 alarm_tx", alarm_tx, 0);
        check("R1 far_fault", far_fault, 0);
        check("R1 rx_carrier", rx_carrier, 0);
        check("R1 mii_tx_ok", mii_tx_ok, 1);
        check("R1 mii_rx_ok", mii_rx_ok, 1);
        rst_n = 1'b1;
        step();

        // R2: passthrough with no alarm
        for (int i = 0; i < 24; i++) begin
            expb = ((i * 7) >> 2) & 1;
            txs_in = expb;
            step();
            check("R2 passthrough", txs_out, expb);
        end
        txs_in = 1'b1;

        // R4/R5: a fault session at every group phase
        for (int ph = 0; ph < 5; ph++) tx_session(ph);

        // R3: enabled but no good link since the signal returned
        cfg_enable = 1'b0;
        sig_present = 1'b0;
        step();
        cfg_enable = 1'b1;
        sig_present = 1'b1;
        link_good = 1'b0;
        repeat (4) step();
        sig_present = 1'b0;
        repeat (2) step();
        check("R3 no alarm without good link", alarm_tx, 0);

        // R3: disabled function never alarms
        arm();
        cfg_enable = 1'b0;
        sig_present = 1'b0;
        repeat (2) step();
        check("R3 no alarm when disabled", alarm_tx, 0);

        // R5: disable ends an alarm
        arm();
        sig_present = 1'b0;
        step();
        check("R5 alarm up before disable", alarm_tx, 1);
        cfg_enable = 1'b0;
        step();
        check("R5 alarm ends on disable", alarm_tx, 0);
        cfg_enable = 1'b1;
        sig_present = 1'b1;
        link_good = 1'b0;
        step();

        // R6/R7/R10: run-length sweep around the threshold
        for (int len = 80; len <= 88; len++) begin
            c0 = carr_cnt;
            rx_pre();
            rx_pat(len);
            rx_pat(len);
            rx_send(1'b1);
            rx_send(1'b1);
            check("R6 two patterns leave flag clear", far_fault, 0);
            rx_pat(len);
            rx_send(1'b1);
            rx_send(1'b1);
            check("R6 R7 flag after third pattern", far_fault, (len >= 84) ? 1 : 0);
            check("R10 pattern is not carrier", carr_cnt - c0, 0);
            if (far_fault) begin
                check("R9 tx blocked by flag", mii_tx_ok, 0);
                check("R9 rx blocked by flag", mii_rx_ok, 0);
                do_read();
                check("R8 read clears flag", far_fault, 0);
                check("R9 rx reopened", mii_rx_ok, 1);
            end
        end

        // R7: short run between patterns restarts the count
        rx_pre();
        rx_pat(84);
        rx_pat(84);
        for (int i = 0; i < 50; i++) rx_send(1'b1);
        rx_send(1'b0);
        rx_pat(84);
        rx_pat(84);
        rx_send(1'b1);
        rx_send(1'b1);
        check("R7 count restarted by short run", far_fault, 0);
        rx_pat(84);
        rx_send(1'b1);
        rx_send(1'b1);
        check("R7 third after restart sets", far_fault, 1);
        do_read();

        // R7: double zero after a pattern restarts the count
        c0 = carr_cnt;
        rx_pre();
        rx_pat(84);
        rx_pat(84);
        rx_send(1'b0);
        rx_pat(84);
        rx_pat(84);
        rx_send(1'b1);
        rx_send(1'b1);
        check("R7 double zero restarts count", far_fault, 0);
        check("R10 double zero is carrier", carr_cnt - c0, 1);

        // R8: read in the same clock as the setting event
        rx_pre();
        rx_pat(84);
        rx_pat(84);
        rx_pat(84);
        rx_send(1'b1);
        do_read();
        check("R8 set wins over coincident read", far_fault, 1);
        do_read();
        check("R8 later read clears", far_fault, 0);
        rx_pat(84);
        rx_send(1'b1);
        rx_send(1'b1);
        check("R6 fourth pattern sets again", far_fault, 1);
        do_read();
        check("R8 cleared after fourth", far_fault, 0);

        // R11: disabled detection, then a fresh count
        cfg_enable = 1'b0;
        rx_pre();
        for (int i = 0; i < 4; i++) rx_pat(84);
        rx_send(1'b1);
        rx_send(1'b1);
        check("R11 no flag while disabled", far_fault, 0);
        cfg_enable = 1'b1;
        rx_pat(84);
        rx_pat(84);
        rx_send(1'b1);
        rx_send(1'b1);
        check("R11 count restarts on enable", far_fault, 0);
        rx_pat(84);
        rx_send(1'b1);
        rx_send(1'b1);
        check("R11 third after enable sets", far_fault, 1);
        do_read();

        // R10: carrier gap sweep
        for (int g = 0; g <= 12; g++) begin
            for (int i = 0; i < 15; i++) rx_send(1'b1);
            rx_send(1'b0);
            check("R10 isolated zero", rx_carrier, 0);
            for (int i = 0; i < g; i++) rx_send(1'b1);
            rx_send(1'b0);
            check("R10 close zero pair", rx_carrier, (g < 10) ? 1 : 0);
        end
        rx_send(1'b1);
        step();
        check("R11 carrier zeros never set flag", far_fault, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule